// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block holds the program counter of a 32-bit processor whose instructions sit on word boundaries, and it chooses the address of the next instruction. The inputs are the fetched instruction word and the values of its two source registers. From the opcode and function fields the block decides whether control continues in sequence, takes an equality branch, jumps to a region-local target, jumps and links, or jumps through a register.

The surrounding core feeds the fetched word and the register-file outputs to the block. It advances the counter by raising the enable input. When the instruction is a jump-and-link, the block also produces a write request for the return address, aimed at register 31. The combinational next-address output lets fetch logic see where the counter is heading before the clock edge.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads the program counter with the parameter RESET_VEC (default 32'h0040_0000).
- R2: While the enable input is low, the program counter keeps its value and the link write request stays low.
- R3: An instruction that is not one of the control transfers below sets the next PC to PC+4.
- R4: Opcode 4 in bits 31:26 is a branch-if-equal. When rs_val equals rt_val, the next PC is PC+4 plus bits 15:0 sign-extended and shifted left by two. Otherwise it is PC+4.
- R5: Opcode 5 is a branch-if-not-equal. It uses the same target as R4 and is taken only when rs_val and rt_val differ. Otherwise the next PC is PC+4.
- R6: Opcode 2 is a jump. The next PC is PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R7: Opcode 3 is jump-and-link. It takes the R6 target, and in the same enabled cycle it raises the link write request with link data PC+4 and link index 31.
- R8: Opcode 0 with function code 8 in bits 5:0 is jump-register. The next PC is the full 32-bit rs_val.
- R9: The link write request is low for every instruction other than jump-and-link. It lasts exactly one cycle per enabled jump-and-link.
- R10: The next-PC output equals the value the program counter takes at the following enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the program counter this cycle |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| npc | output | 32 | Next program counter (combinational) |
| link_we | output | 1 | Return-address write request |
| link_data | output | 32 | Return address to write |
| link_idx | output | 5 | Destination register of the return address |

## Verification
The program counter is the block's only state, and it is visible at the pc port. A wrong target or a wrong taken decision therefore shows at the next enabled edge, and every later address is then offset from the expected one. The bench keeps its own model of the counter and compares the port one cycle after each instruction, so a single wrong update is reported at the step that caused it. A link request raised at the wrong time shows in the same cycle as the instruction, which is the cycle in which the bench samples it.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] npc,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic [4:0]  link_idx
);
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_JLINK   = 6'd3;
  localparam logic [5:0] OP_BREQ    = 6'd4;
  localparam logic [5:0] OP_BRNE    = 6'd5;
  localparam logic [5:0] FN_JREG    = 6'd8;
  localparam logic [4:0] LINK_REG   = 5'd31;

  logic [5:0]  opcode, funct;
  logic [31:0] seq_pc, br_pc, jmp_pc;
  logic        same;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign seq_pc = pc + 32'd4;
  assign br_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_pc = {pc[31:28], instr[25:0], 2'b00};
  assign same   = (rs_val == rt_val);

  always_comb begin
    case (opcode)
      OP_BREQ:    npc = same  ? br_pc : seq_pc;
      OP_BRNE:    npc = !same ? br_pc : seq_pc;
      OP_JUMP:    npc = jmp_pc;
      OP_JLINK:   npc = jmp_pc;
      OP_SPECIAL: npc = (funct == FN_JREG) ? rs_val : seq_pc;
      default:    npc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     pc <= RESET_VEC;
    else if (en) pc <= npc;
  end

  assign link_we   = en && !rst && (opcode == OP_JLINK);
  assign link_data = seq_pc;
  assign link_idx  = LINK_REG;
endmodule

module npc_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc,
  input logic [31:0] npc,
  input logic        link_we,
  input logic [31:0] link_data,
  input logic [4:0]  link_idx
);
  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> pc == RESET_VEC);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(pc));
  // R2
  no_link_idle_chk: assert property (@(posedge clk) !en |-> !link_we);
  // R10
  npc_follow_chk: assert property (@(posedge clk) disable iff (rst) en |=> pc == $past(npc));
  // R4
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (en && instr[31:26] == 6'd4 && rs_val == rt_val) |=>
    pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});
  // R5
  bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (en && instr[31:26] == 6'd5 && rs_val == rt_val) |=> pc == $past(pc) + 32'd4);
  // R7
  jal_target_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});
  // R7
  jal_link_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_idx == 5'd31 && link_data == pc + 32'd4));
  // R8
  jr_chk: assert property (@(posedge clk) disable iff (rst)
    (en && instr[31:26] == 6'd0 && instr[5:0] == 6'd8) |=> pc == $past(rs_val));
  // R9
  link_only_jal_chk: assert property (@(posedge clk) link_we |-> instr[31:26] == 6'd3);
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic clk = 0, rst = 1, en = 0;
  logic [31:0] instr = 0, rs_val = 0, rt_val = 0;
  logic [31:0] pc, npc, link_data;
  logic link_we;
  logic [4:0] link_idx;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_pc;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) u_npc_unit (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .npc(npc), .link_we(link_we), .link_data(link_data), .link_idx(link_idx));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction
  function automatic logic [31:0] jtype(input logic [5:0] op, input logic [25:0] a);
    return {op, a};
  endfunction

  // monitor: pops the expected PC one cycle after each driven step
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pc, e);
    end
  end

  task automatic step(input string req, input logic e, input logic [31:0] ins,
                      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] nxt, seq, br;
    logic is_jal;
    @(negedge clk); #1;
    en = e; instr = ins; rs_val = a; rt_val = b;
    seq = exp_pc + 4;
    br  = seq + ({{16{ins[15]}}, ins[15:0]} << 2);
    is_jal = (ins[31:26] == 6'd3);
    case (ins[31:26])
      6'd4: nxt = (a == b) ? br : seq;
      6'd5: nxt = (a != b) ? br : seq;
      6'd2, 6'd3: nxt = {exp_pc[31:28], ins[25:0], 2'b00};
      6'd0: nxt = (ins[5:0] == 6'd8) ? a : seq;
      default: nxt = seq;
    endcase
    #1;
    check({req, " npc"}, npc, nxt);
    check({req, " link_we"}, {31'd0, link_we}, {31'd0, e && is_jal});
    if (e && is_jal) begin
      check("R7 link_data", link_data, seq);
      check("R7 link_idx", {27'd0, link_idx}, 32'd31);
    end
    if (e) exp_pc = nxt;
    exp_q.push_back(exp_pc);
    tag_q.push_back(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    exp_pc = RV;
    check("R1 reset pc", pc, RV);
    step("R3 seq r-type", 1, 32'h0022_1820, 0, 0);
    step("R3 seq load", 1, itype(6'd35, 16'h0010), 0, 0);
    step("R4 beq taken fwd", 1, itype(6'd4, 16'h0003), 32'h55, 32'h55);
    step("R4 beq not taken", 1, itype(6'd4, 16'h0003), 32'h55, 32'h56);
    step("R4 beq taken back", 1, itype(6'd4, 16'hFFFC), 7, 7);
    step("R5 bne taken", 1, itype(6'd5, 16'hFFFE), 1, 2);
    step("R5 bne not taken", 1, itype(6'd5, 16'h0040), 9, 9);
    step("R8 jr", 1, 32'h03E0_0008, 32'hA000_0010, 0);
    step("R6 jump keeps top bits", 1, jtype(6'd2, 26'h3FF_FFFF), 0, 0);
    step("R7 jal", 1, jtype(6'd3, 26'h000_0123), 0, 0);
    step("R9 seq no link", 1, 32'h0000_0020, 0, 0);
    step("R2 hold jal", 0, jtype(6'd3, 26'h0AB_CDEF), 0, 0);
    step("R2 hold jr", 0, 32'h03E0_0008, 32'h1234_5678, 0);
    step("R8 jr funct other", 1, 32'h03E0_0009, 32'h1234_5678, 0);
    step("R7 jal again", 1, jtype(6'd3, 26'h200_0000), 0, 0);
    @(negedge clk); en = 0;
    @(negedge clk); #1;
    // R1 reset mid-run
    rst = 1;
    @(negedge clk); #1;
    check("R1 reset mid-run", pc, RV);
    check("R9 no link in reset", {31'd0, link_we}, 32'd0);
    rst = 0;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule